// File: doc/BRIEF.md
# Indirect Configuration and MDIO Access Bridge

This block gives a host processor access to a bank of MAC configuration registers and to a clause-22 MDIO management bus through a small window of three directly addressed words. The host places an operand in the data word and then writes the control word. That control write launches exactly one access: a configuration read, a configuration write, an MDIO read or an MDIO write. The host then polls the ready word until the flag for that kind of access comes back. A read returns its result in the data word.

The configuration bank holds these registers: the receive and transmit enables, the link speed, the management settings (MDIO enable and MDC divider), the 48-bit station address, and the accept-all filter bit. The register values also drive the block's side outputs. An MDIO transaction starts when the control word names the MDIO address slot. For a write, the data halfword is staged beforehand in its own slot, and the MDIO master runs a full 64-bit frame on MDC/MDIO.

Top module: `cfg_mdio_bridge`

## Requirements
- R1: After reset the data and control words read 0, the ready word reads 0x66 (all four completion flags set), and the receive and transmit enables are low.
- R2: The data word is at host address 0x24, the control word at 0x28 and the ready word at 0x2C. The control word reads back the last accepted control value, and any other host address reads 0.
- R3: A control write with bit 15 set and offset bits [9:0] is a configuration write of the data word. Ready bit 6 reads 0 in the cycle after the control write and returns to 1 CFG_LAT cycles after that write.
- R4: A control write with bit 15 clear is a configuration read. Ready bit 5 clears in the same way, and when it sets the register value is in the data word.
- R5: Bits [11:10] of the control word select the instance, and only instance 0 exists. An access to another instance, or to an offset with no register, reads 0 and changes nothing.
- R6: Bit 28 of offset 0x240 is the receive enable and bit 28 of offset 0x280 is the transmit enable. Writing 0x10000000 sets the enable and writing 0 clears it.
- R7: Bits [31:30] of offset 0x300 drive link_speed (00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1000 Mb/s). All 32 bits are kept, so a read-modify-write preserves the other bits.
- R8: Offset 0x380 holds address bytes 3..0, with byte 0 in bits [7:0]. Offset 0x384 holds bytes 5..4 in bits [15:0], and its upper bits read 0. mac_addr presents byte k in bits [8k+7:8k].
- R9: At offset 0x340, bit 6 enables MDIO and bits [5:0] give the divider d, so the MDC period is 2*(d+1) clock cycles. While MDIO is disabled, an MDIO access completes one cycle after its control write, MDC never toggles, and a read returns 0xFFFF.
- R10: A control write of offset 0x3B4 with bit 15 set sends an MDIO write frame. The frame is 32 ones, then 01, then op 01, then the PHY address taken from data bits [9:5], then the register number from data bits [4:0], then turnaround 10, then the halfword staged at offset 0x3B0. Ready bit 2 flags completion.
- R11: A control write of offset 0x3B4 with bit 15 clear sends a read frame with op 10. The master releases the line from the turnaround onward and captures 16 bits MSB first into data bits [15:0], with the upper bits 0. Ready bit 1 flags completion. A PHY that never drives the line yields 0xFFFF.
- R12: At most one access is in flight. A control write that arrives while an access is in flight is ignored: the control readback, the registers and the ready flags do not change.
- R13: mdio_oe is low and MDC holds still whenever no MDIO access is outstanding.
- R14: Bit 31 of offset 0x390 drives accept_all. The other bits of that offset read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | HADDR_W | Host byte address of a direct word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| mdc | output | 1 | MDIO clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data (pulled high externally) |
| rx_enable | output | 1 | Receive path enable |
| tx_enable | output | 1 | Transmit path enable |
| link_speed | output | 2 | Link speed code |
| mac_addr | output | 48 | Station address, byte 0 in the low lane |
| accept_all | output | 1 | Accept-all filter mode |

## Verification
The assertions watch, on every cycle, the properties that hold at any instant. At most one access is outstanding. An issued access clears its own completion flag on the next cycle. A control write made while busy leaves the control word untouched. MDC and the MDIO output enable stay quiet outside an MDIO access. A completed MDIO read leaves zeros in the upper data bits. Only the bench scenarios can show that values actually arrive in the right places. Those scenarios cover the exact configuration latency, the read-modify-write of the speed field, the byte lanes of the station address, the bit-exact MDIO frame and the MDC period seen by a modelled PHY, the all-ones result when no PHY answers, and an ignored control write that leaves the outputs unchanged.

// File: rtl/cfgbr_pkg.sv
package cfgbr_pkg;

    // direct window byte addresses
    localparam int DIR_DATA = 'h24;
    localparam int DIR_CTRL = 'h28;
    localparam int DIR_RDY  = 'h2C;

    localparam int OFF_W    = 10;
    localparam int WE_BIT   = 15;
    localparam int INST_LSB = 10;
    localparam int MDEN_BIT = 6;

    // indirect offsets
    localparam logic [OFF_W-1:0] IX_RXCFG  = 10'h240;
    localparam logic [OFF_W-1:0] IX_TXCFG  = 10'h280;
    localparam logic [OFF_W-1:0] IX_LINK   = 10'h300;
    localparam logic [OFF_W-1:0] IX_MGMT   = 10'h340;
    localparam logic [OFF_W-1:0] IX_STA_LO = 10'h380;
    localparam logic [OFF_W-1:0] IX_STA_HI = 10'h384;
    localparam logic [OFF_W-1:0] IX_FILT   = 10'h390;
    localparam logic [OFF_W-1:0] IX_MDWD   = 10'h3B0;
    localparam logic [OFF_W-1:0] IX_MDAI   = 10'h3B4;

    // ready word bit positions
    localparam int RB_MD_RD = 1;
    localparam int RB_MD_WR = 2;
    localparam int RB_CF_RD = 5;
    localparam int RB_CF_WR = 6;

    localparam int FRAME_LEN = 64;

    typedef struct packed {
        logic             we;
        logic [1:0]       inst;
        logic [OFF_W-1:0] off;
    } ctl_t;

    typedef struct packed {
        logic md_rd;
        logic md_wr;
        logic cf_rd;
        logic cf_wr;
    } done_t;

    typedef enum logic {MD_IDLE, MD_RUN} md_state_e;

    function automatic ctl_t ctl_decode(input logic [31:0] w);
        ctl_t c;
        c.we   = w[WE_BIT];
        c.inst = w[INST_LSB+1:INST_LSB];
        c.off  = w[OFF_W-1:0];
        return c;
    endfunction

    function automatic logic [31:0] ready_word(input done_t d);
        logic [31:0] r;
        r = '0;
        r[RB_MD_RD] = d.md_rd;
        r[RB_MD_WR] = d.md_wr;
        r[RB_CF_RD] = d.cf_rd;
        r[RB_CF_WR] = d.cf_wr;
        return r;
    endfunction

    function automatic logic [FRAME_LEN-1:0] md_frame(input logic rd,
                                                      input logic [4:0] phy,
                                                      input logic [4:0] ra,
                                                      input logic [15:0] wd);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra,
                (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : wd)};
    endfunction

endpackage

// File: rtl/cfgbr_regs.sv
module cfgbr_regs
    import cfgbr_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [OFF_W-1:0]     wr_off,
    input  logic [31:0]          wr_data,
    input  logic [OFF_W-1:0]     rd_off,
    output logic [31:0]          rd_data,
    output logic                 rx_en,
    output logic                 tx_en,
    output logic [1:0]           speed,
    output logic [47:0]          sta_addr,
    output logic                 acc_all,
    output logic                 md_en,
    output logic [DIV_W-1:0]     md_div,
    output logic [15:0]          md_wdata
);
    logic [31:0]      rx_q, tx_q, link_q, sta_lo_q;
    logic [15:0]      sta_hi_q, mdwd_q;
    logic             filt_q, mden_q;
    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0; tx_q <= '0; link_q <= '0; sta_lo_q <= '0;
            sta_hi_q <= '0; mdwd_q <= '0; filt_q <= 1'b0;
            mden_q <= 1'b0; div_q <= '0;
        end else if (wr_en) begin
            unique case (wr_off)
                IX_RXCFG:  rx_q     <= wr_data;
                IX_TXCFG:  tx_q     <= wr_data;
                IX_LINK:   link_q   <= wr_data;
                IX_MGMT: begin
                    mden_q <= wr_data[MDEN_BIT];
                    div_q  <= wr_data[DIV_W-1:0];
                end
                IX_STA_LO: sta_lo_q <= wr_data;
                IX_STA_HI: sta_hi_q <= wr_data[15:0];
                IX_FILT:   filt_q   <= wr_data[31];
                IX_MDWD:   mdwd_q   <= wr_data[15:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_off)
            IX_RXCFG:  rd_data = rx_q;
            IX_TXCFG:  rd_data = tx_q;
            IX_LINK:   rd_data = link_q;
            IX_MGMT:   rd_data = 32'(div_q) | (32'(mden_q) << MDEN_BIT);
            IX_STA_LO: rd_data = sta_lo_q;
            IX_STA_HI: rd_data = {16'h0, sta_hi_q};
            IX_FILT:   rd_data = {filt_q, 31'h0};
            IX_MDWD:   rd_data = {16'h0, mdwd_q};
            default:   rd_data = '0;
        endcase
    end

    assign rx_en    = rx_q[28];
    assign tx_en    = tx_q[28];
    assign speed    = link_q[31:30];
    assign sta_addr = {sta_hi_q, sta_lo_q};
    assign acc_all  = filt_q;
    assign md_en    = mden_q;
    assign md_div   = div_q;
    assign md_wdata = mdwd_q;

endmodule

// File: rtl/cfgbr_mdio.sv
module cfgbr_mdio
    import cfgbr_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             start,
    input  logic             op_rd,
    input  logic [4:0]       phy,
    input  logic [4:0]       regad,
    input  logic [15:0]      wdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i,
    output logic             done,
    output logic [15:0]      rdata
);
    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] TA_BIT   = IDX_W'(46);
    localparam logic [IDX_W-1:0] DATA_BIT = IDX_W'(48);

    md_state_e            st_q;
    logic [DIV_W-1:0]     hcnt_q;
    logic [IDX_W-1:0]     idx_q;
    logic [FRAME_LEN-1:0] frame_q;
    logic                 rd_q, mdc_q, done_q;
    logic [15:0]          shift_q, rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= MD_IDLE; hcnt_q <= '0; idx_q <= '0; frame_q <= '0;
            rd_q <= 1'b0; mdc_q <= 1'b0; done_q <= 1'b0;
            shift_q <= '0; rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                MD_IDLE: begin
                    if (start) begin
                        if (!en) begin
                            done_q  <= 1'b1;
                            rdata_q <= 16'hFFFF;
                        end else begin
                            st_q    <= MD_RUN;
                            frame_q <= md_frame(op_rd, phy, regad, wdata);
                            rd_q    <= op_rd;
                            idx_q   <= '0;
                            hcnt_q  <= '0;
                            mdc_q   <= 1'b0;
                        end
                    end
                end
                MD_RUN: begin
                    if (hcnt_q == div) begin
                        hcnt_q <= '0;
                        if (!mdc_q) begin
                            mdc_q <= 1'b1;
                            if (rd_q && idx_q >= DATA_BIT)
                                shift_q <= {shift_q[14:0], mdio_i};
                        end else begin
                            mdc_q <= 1'b0;
                            if (idx_q == LAST_BIT) begin
                                st_q    <= MD_IDLE;
                                done_q  <= 1'b1;
                                rdata_q <= rd_q ? shift_q : 16'h0;
                            end else begin
                                idx_q   <= idx_q + 1'b1;
                                frame_q <= {frame_q[FRAME_LEN-2:0], 1'b0};
                            end
                        end
                    end else begin
                        hcnt_q <= hcnt_q + 1'b1;
                    end
                end
                default: st_q <= MD_IDLE;
            endcase
        end
    end

    assign mdc     = mdc_q;
    assign mdio_o  = (st_q == MD_RUN) ? frame_q[FRAME_LEN-1] : 1'b0;
    assign mdio_oe = (st_q == MD_RUN) && !(rd_q && idx_q >= TA_BIT);
    assign done    = done_q;
    assign rdata   = rdata_q;

endmodule

// File: rtl/cfg_mdio_bridge.sv
module cfg_mdio_bridge
    import cfgbr_pkg::*;
#(
    parameter int HADDR_W = 8,
    parameter int CFG_LAT = 2,
    parameter int INST_ID = 0,
    parameter int DIV_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe,
    input  logic               mdio_i,
    output logic               rx_enable,
    output logic               tx_enable,
    output logic [1:0]         link_speed,
    output logic [47:0]        mac_addr,
    output logic               accept_all
);
    localparam int CNT_W = $clog2(CFG_LAT + 1);
    localparam logic [HADDR_W-1:0] A_DATA = HADDR_W'(DIR_DATA);
    localparam logic [HADDR_W-1:0] A_CTRL = HADDR_W'(DIR_CTRL);
    localparam logic [HADDR_W-1:0] A_RDY  = HADDR_W'(DIR_RDY);
    localparam logic [1:0]         MY_INST = 2'(INST_ID);

    logic [31:0]      data_q, ctl_q;
    done_t            done_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_we, pend_ok, md_pend, md_op_rd;
    logic [OFF_W-1:0] pend_off;

    ctl_t             dc;
    logic             ctl_hit, busy, accept, inst_ok, is_md, md_start;
    logic             reg_wr;
    logic [31:0]      reg_rd;
    logic             md_en, md_done;
    logic [DIV_W-1:0] md_div;
    logic [15:0]      md_wdata, md_rdata;

    assign dc       = ctl_decode(host_wdata);
    assign ctl_hit  = host_we && (host_addr == A_CTRL);
    assign busy     = (cnt_q != '0) || md_pend;
    assign accept   = ctl_hit && !busy;
    assign inst_ok  = (dc.inst == MY_INST);
    assign is_md    = inst_ok && (dc.off == IX_MDAI);
    assign md_start = accept && is_md;
    assign reg_wr   = (cnt_q == CNT_W'(1)) && pend_we && pend_ok;

    cfgbr_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr), .wr_off(pend_off), .wr_data(data_q),
        .rd_off(pend_off), .rd_data(reg_rd),
        .rx_en(rx_enable), .tx_en(tx_enable), .speed(link_speed),
        .sta_addr(mac_addr), .acc_all(accept_all),
        .md_en(md_en), .md_div(md_div), .md_wdata(md_wdata)
    );

    cfgbr_mdio #(.DIV_W(DIV_W)) u_mdio (
        .clk(clk), .rst(rst), .en(md_en), .div(md_div),
        .start(md_start), .op_rd(!dc.we),
        .phy(data_q[9:5]), .regad(data_q[4:0]), .wdata(md_wdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
        .done(md_done), .rdata(md_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q   <= '0;
            ctl_q    <= '0;
            done_q   <= '1;
            cnt_q    <= '0;
            pend_we  <= 1'b0;
            pend_ok  <= 1'b0;
            pend_off <= '0;
            md_pend  <= 1'b0;
            md_op_rd <= 1'b0;
        end else begin
            if (host_we && host_addr == A_DATA)
                data_q <= host_wdata;
            if (accept) begin
                ctl_q <= host_wdata;
                if (is_md) begin
                    md_pend  <= 1'b1;
                    md_op_rd <= !dc.we;
                    if (dc.we) done_q.md_wr <= 1'b0;
                    else       done_q.md_rd <= 1'b0;
                end else begin
                    cnt_q    <= CNT_W'(CFG_LAT);
                    pend_we  <= dc.we;
                    pend_off <= dc.off;
                    pend_ok  <= inst_ok;
                    if (dc.we) done_q.cf_wr <= 1'b0;
                    else       done_q.cf_rd <= 1'b0;
                end
            end
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    if (pend_we) begin
                        done_q.cf_wr <= 1'b1;
                    end else begin
                        done_q.cf_rd <= 1'b1;
                        data_q       <= pend_ok ? reg_rd : 32'h0;
                    end
                end
            end
            if (md_done) begin
                md_pend <= 1'b0;
                if (md_op_rd) begin
                    done_q.md_rd <= 1'b1;
                    data_q       <= {16'h0, md_rdata};
                end else begin
                    done_q.md_wr <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (host_addr == A_DATA)      host_rdata = data_q;
        else if (host_addr == A_CTRL) host_rdata = ctl_q;
        else if (host_addr == A_RDY)  host_rdata = ready_word(done_q);
        else                          host_rdata = '0;
    end

endmodule

// File: rtl/cfgbr_chk.sv
module cfgbr_chk (
    input logic        clk,
    input logic        rst,
    input logic        ctl_hit,
    input logic        busy,
    input logic        ctl_we,
    input logic        md_start,
    input logic [31:0] ctl_q,
    input logic [31:0] data_q,
    input logic [3:0]  done_vec,
    input logic        md_pend,
    input logic        mdc,
    input logic        mdio_oe
);
    // done_vec = {md_rd, md_wr, cf_rd, cf_wr}

    a_r1_flags_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> done_vec == 4'hF);

    a_r3_cfg_wr_clears: assert property (@(posedge clk) disable iff (rst)
        (ctl_hit && !busy && ctl_we && !md_start) |=> !done_vec[0]);

    a_r4_cfg_rd_clears: assert property (@(posedge clk) disable iff (rst)
        (ctl_hit && !busy && !ctl_we && !md_start) |=> !done_vec[1]);

    a_r11_upper_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(done_vec[3]) |-> data_q[31:16] == 16'h0);

    a_r12_busy_ignored: assert property (@(posedge clk) disable iff (rst)
        (ctl_hit && busy) |=> $stable(ctl_q));

    a_r12_single_flight: assert property (@(posedge clk) disable iff (rst)
        $countones(~done_vec) <= 1);

    a_r13_mdc_in_xfer: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdc) |-> $past(md_pend));

    a_r13_oe_idle: assert property (@(posedge clk) disable iff (rst)
        !md_pend |-> !mdio_oe);

endmodule

bind cfg_mdio_bridge cfgbr_chk u_chk (
    .clk(clk), .rst(rst), .ctl_hit(ctl_hit), .busy(busy), .ctl_we(dc.we),
    .md_start(md_start), .ctl_q(ctl_q), .data_q(data_q), .done_vec(done_q),
    .md_pend(md_pend), .mdc(mdc), .mdio_oe(mdio_oe)
);

// File: tb/cfg_mdio_bridge_test.sv
module cfg_mdio_bridge_test;
    localparam int CLK_P   = 10;
    localparam int CFG_LAT = 2;
    localparam logic [4:0] PHY_AD = 5'd3;
    localparam logic [7:0] A_DATA = 8'h24, A_CTRL = 8'h28, A_RDY = 8'h2C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;
    logic        rx_enable, tx_enable, accept_all;
    logic [1:0]  link_speed;
    logic [47:0] mac_addr;

    always #(CLK_P/2) clk = ~clk;

    cfg_mdio_bridge #(.CFG_LAT(CFG_LAT)) uut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
        .rx_enable(rx_enable), .tx_enable(tx_enable), .link_speed(link_speed),
        .mac_addr(mac_addr), .accept_all(accept_all)
    );

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard
    typedef struct {
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } item_t;
    item_t sbq[$];
    logic  smp = 1'b0;

    always @(posedge clk) begin
        if (smp) begin
            #(CLK_P/4);
            if (sbq.size() == 0) begin
                check("scoreboard underflow", 64'd1, 64'd0);
            end else begin
                item_t it;
                it = sbq.pop_front();
                check(it.tag, 64'(host_rdata & it.mask), 64'(it.exp & it.mask));
            end
        end
    end

    // PHY responder
    logic [15:0] phy_mem [32];
    logic [6:0]  pb = '0;
    logic [63:0] pcap = '0, last_frame = '0;
    logic        prd = 1'b0;
    logic [15:0] pword = '0;
    time         last_rise = 0, md_period = 0;
    int          mdc_rises = 0;

    always @(posedge mdc) begin
        mdc_rises++;
        if (pb == 7'd1) md_period = $time - last_rise;
        last_rise = $time;
        if (pb != 0 || mdio_oe) begin
            pcap = {pcap[62:0], (mdio_oe ? mdio_o : mdio_i)};
            if (pb == 7'd45) begin
                prd   = (pcap[11:10] == 2'b10) && (pcap[9:5] == PHY_AD);
                pword = phy_mem[pcap[4:0]];
            end
            if (pb == 7'd46 && prd)                 mdio_i = 1'b0;
            else if (pb >= 7'd47 && pb <= 7'd62 && prd) mdio_i = pword[62-pb];
            else                                    mdio_i = 1'b1;
            if (pb == 7'd63) begin
                last_frame = pcap;
                if (pcap[29:28] == 2'b01 && pcap[27:23] == PHY_AD)
                    phy_mem[pcap[22:18]] = pcap[15:0];
                pb  = '0;
                prd = 1'b0;
            end else begin
                pb = pb + 1'b1;
            end
        end
    end

    // driver tasks: each starts and ends at a falling clock edge
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e,
                             input logic [31:0] m, input string tag);
        item_t it;
        it.exp = e; it.mask = m; it.tag = tag;
        sbq.push_back(it);
        host_addr = a; smp = 1'b1;
        @(negedge clk);
        smp = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        host_addr = a;
        @(posedge clk);
        #1 v = host_rdata;
        @(negedge clk);
    endtask

    task automatic wait_rdy(input int b);
        logic [31:0] v;
        int n;
        n = 0;
        v = '0;
        while (!v[b] && n < 20000) begin
            peek(A_RDY, v);
            n++;
        end
        if (!v[b]) check("ready poll timeout", 64'd0, 64'd1);
    endtask

    task automatic cfg_wr(input logic [9:0] off, input logic [31:0] val);
        bus_wr(A_DATA, val);
        bus_wr(A_CTRL, 32'h8000 | 32'(off));
        wait_rdy(6);
    endtask

    task automatic cfg_rd(input logic [31:0] ctl, input logic [31:0] e, input string tag);
        bus_wr(A_CTRL, ctl);
        wait_rdy(5);
        expect_rd(A_DATA, e, '1, tag);
    endtask

    task automatic md_wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] val);
        cfg_wr(10'h3B0, 32'(val));
        bus_wr(A_DATA, 32'({phy, ra}));
        bus_wr(A_CTRL, 32'h8000 | 32'h3B4);
        wait_rdy(2);
    endtask

    task automatic md_rd(input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] e, input string tag);
        bus_wr(A_DATA, 32'({phy, ra}));
        bus_wr(A_CTRL, 32'h3B4);
        wait_rdy(1);
        expect_rd(A_DATA, {16'h0, e}, '1, tag);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 32; i++) phy_mem[i] = 16'(i * 16'h0101);
        phy_mem[7] = 16'h8001;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_rd(A_RDY,  32'h66, '1, "R1 ready after reset");
        expect_rd(A_DATA, 32'h0,  '1, "R1 data after reset");
        expect_rd(A_CTRL, 32'h0,  '1, "R1 control after reset");
        check("R1 rx/tx enables after reset", {62'h0, rx_enable, tx_enable}, 64'h0);

        // R2 window map
        expect_rd(8'h30, 32'h0, '1, "R2 unmapped address");
        bus_wr(A_DATA, 32'hA5A5_1234);
        expect_rd(A_DATA, 32'hA5A5_1234, '1, "R2 data word");

        // R3 latency of a configuration write, R6 receive enable
        bus_wr(A_DATA, 32'h1000_0000);
        bus_wr(A_CTRL, 32'h8240);
        expect_rd(A_RDY, 32'h26, '1, "R3 write flag low one cycle after issue");
        expect_rd(A_RDY, 32'h66, '1, "R3 write flag back after CFG_LAT");
        expect_rd(A_CTRL, 32'h8240, '1, "R2 control readback");
        check("R6 rx enable set", 64'(rx_enable), 64'd1);

        // R4 configuration read
        bus_wr(A_DATA, 32'h0);
        bus_wr(A_CTRL, 32'h0240);
        expect_rd(A_RDY, 32'h46, '1, "R4 read flag low one cycle after issue");
        expect_rd(A_RDY, 32'h66, '1, "R4 read flag back after CFG_LAT");
        expect_rd(A_DATA, 32'h1000_0000, '1, "R4 read result");

        // R6 transmit enable on and off
        cfg_wr(10'h280, 32'h1000_0000);
        check("R6 tx enable set", 64'(tx_enable), 64'd1);
        cfg_wr(10'h280, 32'h0);
        check("R6 tx enable cleared", 64'(tx_enable), 64'd0);

        // R7 link speed with read-modify-write
        cfg_wr(10'h300, 32'h0000_1234);
        bus_wr(A_CTRL, 32'h0300);
        wait_rdy(5);
        peek(A_DATA, v);
        v = (v & ~32'hC000_0000) | 32'h8000_0000;
        cfg_wr(10'h300, v);
        check("R7 speed code 1000", 64'(link_speed), 64'd2);
        cfg_rd(32'h0300, 32'h8000_1234, "R7 other bits kept");
        cfg_wr(10'h300, 32'h4000_1234);
        check("R7 speed code 100", 64'(link_speed), 64'd1);

        // R8 station address lanes
        cfg_wr(10'h380, 32'h4433_2211);
        cfg_wr(10'h384, 32'hABCD_6655);
        check("R8 station address", 64'(mac_addr), 64'h6655_4433_2211);
        cfg_rd(32'h0384, 32'h0000_6655, "R8 high half upper bits zero");

        // R14 accept-all filter
        cfg_wr(10'h390, 32'h8000_0000);
        check("R14 accept_all set", 64'(accept_all), 64'd1);
        cfg_wr(10'h390, 32'h7FFF_FFFF);
        check("R14 accept_all clear", 64'(accept_all), 64'd0);
        cfg_rd(32'h0390, 32'h0, "R14 low bits read zero");

        // R5 unimplemented offset and foreign instance
        cfg_wr(10'h3C0, 32'hDEAD_BEEF);
        cfg_rd(32'h03C0, 32'h0, "R5 unimplemented offset reads zero");
        bus_wr(A_DATA, 32'h0);
        bus_wr(A_CTRL, 32'h8000 | (32'd1 << 10) | 32'h240);
        wait_rdy(6);
        check("R5 foreign instance write ignored", 64'(rx_enable), 64'd1);
        cfg_rd((32'd1 << 10) | 32'h240, 32'h0, "R5 foreign instance reads zero");

        // R9 MDIO disabled
        bus_wr(A_DATA, 32'({PHY_AD, 5'd2}));
        bus_wr(A_CTRL, 32'h3B4);
        expect_rd(A_RDY, 32'h66, '1, "R9 disabled access done next cycle");
        expect_rd(A_DATA, 32'h0000_FFFF, '1, "R9 disabled read all ones");
        check("R9 no MDC while disabled", 64'(mdc_rises), 64'd0);

        // R10 MDIO write frame, R9 period with divider 1
        cfg_wr(10'h340, 32'h41);
        md_wr(PHY_AD, 5'd4, 16'hBEEF);
        check("R10 write frame bits", last_frame,
              {32'hFFFF_FFFF, 2'b01, 2'b01, PHY_AD, 5'd4, 2'b10, 16'hBEEF});
        check("R10 PHY received write", 64'(phy_mem[4]), 64'hBEEF);
        check("R9 MDC period divider 1", 64'(md_period), 64'(4 * CLK_P));

        // R11 MDIO reads
        md_rd(PHY_AD, 5'd4, 16'hBEEF, "R11 read back written value");
        check("R11 read op code", 64'(last_frame[29:28]), 64'd2);
        md_rd(PHY_AD, 5'd7, 16'h8001, "R11 read second register");
        md_rd(5'd9, 5'd4, 16'hFFFF, "R11 absent PHY reads all ones");

        // R12 control write while an MDIO read is in flight
        bus_wr(A_DATA, 32'({PHY_AD, 5'd7}));
        bus_wr(A_CTRL, 32'h3B4);
        bus_wr(A_CTRL, 32'h8280);
        wait_rdy(1);
        expect_rd(A_CTRL, 32'h3B4, '1, "R12 control not overwritten");
        expect_rd(A_RDY, 32'h66, '1, "R12 flags untouched");
        expect_rd(A_DATA, 32'h8001, '1, "R12 in-flight read result");
        check("R12 tx enable unchanged", 64'(tx_enable), 64'd0);

        // R9 slower divider, R13 idle line
        cfg_wr(10'h340, 32'h43);
        md_rd(PHY_AD, 5'd7, 16'h8001, "R9 read with divider 3");
        check("R9 MDC period divider 3", 64'(md_period), 64'(8 * CLK_P));
        check("R13 idle line released", {62'h0, mdio_oe, mdc}, 64'h0);

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule